// File: doc/BRIEF.md
# Dispatch User-Register Preload Sequencer

This block fills the scalar user-data registers that a compute dispatch sees when its first wave starts. It takes a 32-bit property word whose low ten bits choose which optional fields to load. It also takes the dispatch parameters: a 128-bit scratch buffer descriptor, four 64-bit values (dispatch pointer, queue pointer, argument pointer, dispatch ID), a scratch byte offset, a per-item scratch size, and the grid and work-group extents in X, Y and Z. A one-cycle start pulse launches a run.

The block first works out the three grid work-group counts by ceiling division, using one multi-cycle restoring divider per dimension. It then walks the fields in their fixed order and writes one 32-bit word per cycle through an index/data/valid port. Register indices are dense over the enabled fields only and stop at the 16-register limit. After the last write it pulses done and shows the user-register count, which is the total requested and saturates at 16.

Top module: `udpre_top`

## Requirements
- R1: The enable bits are property bits 0..9. In walk order they select: scratch descriptor (bit 0), dispatch pointer (1), queue pointer (2), argument pointer (3), dispatch ID (4), flat scratch init (5), private segment size (6), grid count X (7), Y (8), Z (9). Property bits 10..31 have no effect.
- R2: Field sizes are 4, 2, 2, 2, 2, 2, 1, 1, 1, 1 registers in walk order. The first enabled field starts at index 0, and each later enabled field takes the next free index. A disabled field uses no index.
- R3: No write goes to an index of 16 or above. Registers of enabled fields that would fall there are dropped, and any part of a field below 16 is still written.
- R4: When done is high, `user_cnt` holds the sum of the sizes of the enabled fields, saturated at 16.
- R5: A grid count register holds ceil(grid / wg) in that dimension, for any 32-bit operands.
- R6: A work-group size of zero gives a count of zero. It sets `div_err` when that dimension's count is enabled; a zero size in a disabled dimension leaves `div_err` low.
- R7: The private segment size register holds the per-item size rounded up to a multiple of 4.
- R8: Flat scratch init writes two registers: the scratch byte offset at the lower index, then the rounded per-item size.
- R9: 64-bit fields are written low word first at the lower index. The descriptor is written as its four 32-bit words, lowest first.
- R10: Writes are back to back, one per cycle, with `wr_valid` high. `done` is a one-cycle pulse in the cycle after the last write and never coincides with a write. `busy` is high from the cycle after start until done.
- R11: A start pulse that arrives while `busy` is high is ignored, so the run in progress completes with its original parameters.
- R12: After reset, `wr_valid`, `done`, `busy`, `div_err` and `user_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, sampled when idle |
| props | input | 32 | Property word; bits 0..9 are field enables |
| scr_desc | input | 128 | Scratch buffer descriptor |
| disp_ptr | input | 64 | Dispatch packet address |
| queue_ptr | input | 64 | Queue object address |
| arg_ptr | input | 64 | Argument segment address |
| disp_id | input | 64 | Dispatch identifier |
| scr_off | input | 32 | Scratch byte offset |
| item_size | input | 32 | Per-item scratch bytes |
| grid_x | input | 32 | Grid extent X |
| grid_y | input | 32 | Grid extent Y |
| grid_z | input | 32 | Grid extent Z |
| wg_x | input | 32 | Work-group extent X |
| wg_y | input | 32 | Work-group extent Y |
| wg_z | input | 32 | Work-group extent Z |
| wr_valid | output | 1 | Register write strobe |
| wr_idx | output | 4 | Register index |
| wr_data | output | 32 | Register value |
| done | output | 1 | One-cycle completion pulse |
| user_cnt | output | 5 | Saturated user-register count |
| div_err | output | 1 | Zero work-group size in an enabled dimension |
| busy | output | 1 | Run in progress |

## Verification
The assertions check the shape of the write stream on every cycle. A burst starts at index 0 and steps by one per write. Done lasts one cycle and never coincides with a write. Writes occur only while busy, busy falls only together with done, and the reported count never exceeds 16. What each register holds can only be shown by the bench's scenarios. That covers which fields land at which indices, the rounding, the ceiling quotients, the zero-size error, truncation at 16, and a rejected restart. In each case the bench compares the captured writes against an independent model of the requirements.

// File: rtl/udpre_pkg.sv
package udpre_pkg;
  localparam int NUM_FIELDS = 10;
  localparam int USER_LIMIT = 16;
  localparam int IDX_W      = $clog2(USER_LIMIT);
  localparam int CNT_W      = $clog2(USER_LIMIT + 1);
  localparam int SUM_W      = 5;

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_EMIT} seq_state_e;

  // Register footprint of each optional field, by walk position.
  function automatic logic [2:0] field_regs(input logic [3:0] f);
    case (f)
      4'd0:                          field_regs = 3'd4;
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5:  field_regs = 3'd2;
      default:                       field_regs = 3'd1;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] clamp_total(input logic [NUM_FIELDS-1:0] en);
    logic [SUM_W-1:0] sum;
    sum = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (en[i]) sum = sum + SUM_W'(field_regs(4'(i)));
    clamp_total = (sum > SUM_W'(USER_LIMIT)) ? CNT_W'(USER_LIMIT) : CNT_W'(sum);
  endfunction
endpackage

// File: rtl/udpre_ceil_div.sv
module udpre_ceil_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         ready,
  output logic [W-1:0] quot,
  output logic         dz
);
  localparam int STEP_W = $clog2(W + 2);

  logic              running;
  logic [STEP_W-1:0] step;
  logic [W:0]        rem, q;
  logic [W-1:0]      d;
  logic [W:0]        rem_sh, rem_nx, q_nx;
  logic [W+1:0]      trial;

  always_comb begin
    rem_sh = {rem[W-1:0], q[W]};
    trial  = {1'b0, rem_sh} - {2'b00, d};
    if (!trial[W+1]) begin
      rem_nx = trial[W:0];
      q_nx   = {q[W-1:0], 1'b1};
    end else begin
      rem_nx = rem_sh;
      q_nx   = {q[W-1:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      ready   <= 1'b0;
      dz      <= 1'b0;
      quot    <= '0;
      step    <= '0;
      rem     <= '0;
      q       <= '0;
      d       <= '0;
    end else if (go) begin
      dz   <= (den == '0);
      rem  <= '0;
      d    <= den;
      step <= '0;
      q    <= {1'b0, num} + {1'b0, den} - {{W{1'b0}}, 1'b1};
      if (den == '0) begin
        quot    <= '0;
        ready   <= 1'b1;
        running <= 1'b0;
      end else begin
        ready   <= 1'b0;
        running <= 1'b1;
      end
    end else if (running) begin
      rem  <= rem_nx;
      q    <= q_nx;
      step <= step + 1'b1;
      if (step == STEP_W'(W)) begin
        running <= 1'b0;
        ready   <= 1'b1;
        quot    <= q_nx[W-1:0];
      end
    end
  end
endmodule

// File: rtl/udpre_word_mux.sv
module udpre_word_mux #(
  parameter int DW = 32
) (
  input  logic [3:0]      field,
  input  logic [1:0]      sub,
  input  logic [4*DW-1:0] desc,
  input  logic [2*DW-1:0] dptr,
  input  logic [2*DW-1:0] qptr,
  input  logic [2*DW-1:0] aptr,
  input  logic [2*DW-1:0] did,
  input  logic [DW-1:0]   off,
  input  logic [DW-1:0]   size,
  input  logic [DW-1:0]   cnt_x,
  input  logic [DW-1:0]   cnt_y,
  input  logic [DW-1:0]   cnt_z,
  output logic [DW-1:0]   word
);
  logic [DW-1:0] size_up;
  assign size_up = (size + DW'(3)) & ~DW'(3);

  always_comb begin
    case (field)
      4'd0:    word = desc[sub*DW +: DW];
      4'd1:    word = sub[0] ? dptr[DW +: DW] : dptr[0 +: DW];
      4'd2:    word = sub[0] ? qptr[DW +: DW] : qptr[0 +: DW];
      4'd3:    word = sub[0] ? aptr[DW +: DW] : aptr[0 +: DW];
      4'd4:    word = sub[0] ? did[DW +: DW]  : did[0 +: DW];
      4'd5:    word = sub[0] ? size_up : off;
      4'd6:    word = size_up;
      4'd7:    word = cnt_x;
      4'd8:    word = cnt_y;
      default: word = cnt_z;
    endcase
  end
endmodule

// File: rtl/udpre_top.sv
module udpre_top
  import udpre_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [31:0]      props,
  input  logic [4*DW-1:0]  scr_desc,
  input  logic [2*DW-1:0]  disp_ptr,
  input  logic [2*DW-1:0]  queue_ptr,
  input  logic [2*DW-1:0]  arg_ptr,
  input  logic [2*DW-1:0]  disp_id,
  input  logic [DW-1:0]    scr_off,
  input  logic [DW-1:0]    item_size,
  input  logic [DW-1:0]    grid_x,
  input  logic [DW-1:0]    grid_y,
  input  logic [DW-1:0]    grid_z,
  input  logic [DW-1:0]    wg_x,
  input  logic [DW-1:0]    wg_y,
  input  logic [DW-1:0]    wg_z,
  output logic             wr_valid,
  output logic [IDX_W-1:0] wr_idx,
  output logic [DW-1:0]    wr_data,
  output logic             done,
  output logic [CNT_W-1:0] user_cnt,
  output logic             div_err,
  output logic             busy
);
  localparam int NDIM = 3;

  seq_state_e            state;
  logic [NUM_FIELDS-1:0] en_q;
  logic [4*DW-1:0]       desc_q;
  logic [2*DW-1:0]       dptr_q, qptr_q, aptr_q, did_q;
  logic [DW-1:0]         off_q, size_q;
  logic [3:0]            cur_f;
  logic [1:0]            cur_k;
  logic [CNT_W-1:0]      next_idx;

  logic            launch;
  logic [DW-1:0]   dnum [NDIM];
  logic [DW-1:0]   dden [NDIM];
  logic [DW-1:0]   dquo [NDIM];
  logic [NDIM-1:0] drdy, ddz;

  assign launch  = start && (state == S_IDLE);
  assign busy    = (state != S_IDLE);
  assign dnum[0] = grid_x;
  assign dnum[1] = grid_y;
  assign dnum[2] = grid_z;
  assign dden[0] = wg_x;
  assign dden[1] = wg_y;
  assign dden[2] = wg_z;

  for (genvar g = 0; g < NDIM; g++) begin : g_div
    udpre_ceil_div #(.W(DW)) u_div (
      .clk  (clk),
      .rst  (rst),
      .go   (launch),
      .num  (dnum[g]),
      .den  (dden[g]),
      .ready(drdy[g]),
      .quot (dquo[g]),
      .dz   (ddz[g])
    );
  end

  // Next enabled field at or after the walk pointer.
  logic       nxt_found;
  logic [3:0] nxt_f;
  always_comb begin
    nxt_found = 1'b0;
    nxt_f     = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (!nxt_found && en_q[i] && (4'(i) >= cur_f)) begin
        nxt_found = 1'b1;
        nxt_f     = 4'(i);
      end
    end
  end

  logic [DW-1:0] sel_word;
  udpre_word_mux #(.DW(DW)) u_mux (
    .field(nxt_f),
    .sub  (cur_k),
    .desc (desc_q),
    .dptr (dptr_q),
    .qptr (qptr_q),
    .aptr (aptr_q),
    .did  (did_q),
    .off  (off_q),
    .size (size_q),
    .cnt_x(dquo[0]),
    .cnt_y(dquo[1]),
    .cnt_z(dquo[2]),
    .word (sel_word)
  );

  logic last_sub;
  assign last_sub = ({1'b0, cur_k} + 3'd1) == field_regs(nxt_f);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      en_q     <= '0;
      desc_q   <= '0;
      dptr_q   <= '0;
      qptr_q   <= '0;
      aptr_q   <= '0;
      did_q    <= '0;
      off_q    <= '0;
      size_q   <= '0;
      cur_f    <= '0;
      cur_k    <= '0;
      next_idx <= '0;
      wr_valid <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
      user_cnt <= '0;
      div_err  <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      done     <= 1'b0;
      case (state)
        S_IDLE: begin
          if (launch) begin
            en_q     <= props[NUM_FIELDS-1:0];
            desc_q   <= scr_desc;
            dptr_q   <= disp_ptr;
            qptr_q   <= queue_ptr;
            aptr_q   <= arg_ptr;
            did_q    <= disp_id;
            off_q    <= scr_off;
            size_q   <= item_size;
            cur_f    <= '0;
            cur_k    <= '0;
            next_idx <= '0;
            div_err  <= 1'b0;
            state    <= S_DIV;
          end
        end
        S_DIV: begin
          if (&drdy) begin
            div_err <= |(ddz & en_q[NUM_FIELDS-1 -: NDIM]);
            state   <= S_EMIT;
          end
        end
        default: begin
          if (nxt_found && (next_idx < CNT_W'(USER_LIMIT))) begin
            wr_valid <= 1'b1;
            wr_idx   <= next_idx[IDX_W-1:0];
            wr_data  <= sel_word;
            next_idx <= next_idx + 1'b1;
            if (last_sub) begin
              cur_f <= nxt_f + 4'd1;
              cur_k <= '0;
            end else begin
              cur_f <= nxt_f;
              cur_k <= cur_k + 2'd1;
            end
          end else begin
            done     <= 1'b1;
            user_cnt <= clamp_total(en_q);
            state    <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/udpre_checker.sv
module udpre_checker #(
  parameter int IDX_W = 4,
  parameter int CNT_W = 5,
  parameter int LIMIT = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic [IDX_W-1:0] wr_idx,
  input logic             done,
  input logic [CNT_W-1:0] user_cnt,
  input logic             busy
);
  // R2: a write burst opens at index 0
  assert_first_idx_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |-> wr_idx == '0);

  // R2: consecutive writes take consecutive indices
  assert_idx_step_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && $past(wr_valid)) |-> wr_idx == $past(wr_idx) + 1'b1);

  // R10: done lasts one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: done never coincides with a write
  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_valid);

  // R10: writes only occur while a run is open
  assert_write_busy_R10: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> busy);

  // R11: a run ends only through done
  assert_busy_end_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R4: the reported count saturates at the limit
  assert_cnt_cap_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> user_cnt <= CNT_W'(LIMIT));
endmodule

bind udpre_top udpre_checker #(
  .IDX_W(udpre_pkg::IDX_W),
  .CNT_W(udpre_pkg::CNT_W),
  .LIMIT(udpre_pkg::USER_LIMIT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_valid(wr_valid),
  .wr_idx  (wr_idx),
  .done    (done),
  .user_cnt(user_cnt),
  .busy    (busy)
);

// File: tb/tb_udpre_top.sv
module tb_udpre_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0]  p_props = '0;
  logic [127:0] p_desc  = '0;
  logic [63:0]  p_dp = '0, p_qp = '0, p_ap = '0, p_id = '0;
  logic [31:0]  p_off = '0, p_size = '0;
  logic [31:0]  p_gx = '0, p_gy = '0, p_gz = '0, p_wx = '0, p_wy = '0, p_wz = '0;

  logic        wr_valid, done, div_err, busy;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic [4:0]  user_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  udpre_top dut (
    .clk(clk), .rst(rst), .start(start), .props(p_props), .scr_desc(p_desc),
    .disp_ptr(p_dp), .queue_ptr(p_qp), .arg_ptr(p_ap), .disp_id(p_id),
    .scr_off(p_off), .item_size(p_size),
    .grid_x(p_gx), .grid_y(p_gy), .grid_z(p_gz),
    .wg_x(p_wx), .wg_y(p_wy), .wg_z(p_wz),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data), .done(done),
    .user_cnt(user_cnt), .div_err(div_err), .busy(busy)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // Monitor: captures the write stream and done pulses.
  int          cyc = 0;
  int          nw = 0;
  int          nd = 0;
  int          last_w = 0;
  int          done_c = 0;
  logic [3:0]  got_i [512];
  logic [31:0] got_d [512];
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (wr_valid) begin
      got_i[nw % 512] <= wr_idx;
      got_d[nw % 512] <= wr_data;
      nw     <= nw + 1;
      last_w <= cyc;
    end
    if (done) begin
      nd     <= nd + 1;
      done_c <= cyc;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent model built from the requirements.
  logic [31:0] exp_d [16];
  int          exp_n, exp_cnt;
  bit          exp_err;

  function automatic logic [31:0] ceil_q(input logic [31:0] g, input logic [31:0] w);
    logic [63:0] t;
    if (w == 0) return 32'h0;
    t = (64'(g) + 64'(w) - 64'd1) / 64'(w);
    return t[31:0];
  endfunction

  task automatic build_expected();
    int sizes [10] = '{4, 2, 2, 2, 2, 2, 1, 1, 1, 1};
    logic [31:0] up;
    logic [31:0] w;
    int total = 0;
    up = (p_size + 32'd3) & ~32'd3;
    exp_n = 0;
    for (int f = 0; f < 10; f++) begin
      if (p_props[f]) begin
        total += sizes[f];
        for (int k = 0; k < sizes[f]; k++) begin
          case (f)
            0: w = p_desc[32*k +: 32];
            1: w = (k == 0) ? p_dp[31:0] : p_dp[63:32];
            2: w = (k == 0) ? p_qp[31:0] : p_qp[63:32];
            3: w = (k == 0) ? p_ap[31:0] : p_ap[63:32];
            4: w = (k == 0) ? p_id[31:0] : p_id[63:32];
            5: w = (k == 0) ? p_off : up;
            6: w = up;
            7: w = ceil_q(p_gx, p_wx);
            8: w = ceil_q(p_gy, p_wy);
            default: w = ceil_q(p_gz, p_wz);
          endcase
          if (exp_n < 16) begin
            exp_d[exp_n] = w;
            exp_n++;
          end
        end
      end
    end
    exp_cnt = (total > 16) ? 16 : total;
    exp_err = (p_props[7] && p_wx == 0) || (p_props[8] && p_wy == 0) ||
              (p_props[9] && p_wz == 0);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int base_d);
    for (int i = 0; i < 3000 && nd == base_d; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compare(input string tag, input int base_w, input int base_d);
    check(nd == base_d + 1, {tag, " done count R10"}, nd - base_d, 1);
    check(nw - base_w == exp_n, {tag, " write count R3"}, nw - base_w, exp_n);
    for (int i = 0; i < exp_n && i < nw - base_w; i++) begin
      check(got_i[(base_w + i) % 512] == 4'(i), {tag, " index R2"},
            got_i[(base_w + i) % 512], i);
      check(got_d[(base_w + i) % 512] == exp_d[i], {tag, " data R9"},
            got_d[(base_w + i) % 512], exp_d[i]);
    end
    check(user_cnt == 5'(exp_cnt), {tag, " user count R4"}, user_cnt, exp_cnt);
    check(div_err == exp_err, {tag, " error flag R6"}, div_err, exp_err);
    if (exp_n > 0)
      check(done_c == last_w + 1, {tag, " done after last write R10"}, done_c, last_w + 1);
    check(!busy, {tag, " idle after done R10"}, busy, 0);
  endtask

  task automatic run_case(input string tag);
    int bw, bd;
    build_expected();
    bw = nw;
    bd = nd;
    pulse_start();
    wait_done(bd);
    compare(tag, bw, bd);
  endtask

  task automatic load_defaults();
    p_desc = 128'h44440004_33330003_22220002_11110001;
    p_dp   = 64'hD0D0_0001_0000_1000;
    p_qp   = 64'hC0C0_0002_0000_2000;
    p_ap   = 64'hA0A0_0003_0000_3000;
    p_id   = 64'h1D1D_0004_0000_4000;
    p_off  = 32'h0000_8000;
    p_size = 32'd13;
    p_gx = 32'd100; p_wx = 32'd7;
    p_gy = 32'd64;  p_wy = 32'd8;
    p_gz = 32'd1;   p_wz = 32'd1;
  endtask

  // R12
  task automatic t_reset();
    check(!wr_valid, "reset wr_valid R12", wr_valid, 0);
    check(!done, "reset done R12", done, 0);
    check(!busy, "reset busy R12", busy, 0);
    check(!div_err, "reset div_err R12", div_err, 0);
    check(user_cnt == 0, "reset user_cnt R12", user_cnt, 0);
  endtask

  // R5: grid counts alone, including exact and inexact quotients
  task automatic t_grid();
    load_defaults();
    p_props = 32'h0000_0380;
    run_case("grid R5");
    p_gx = 32'hFFFF_FFFF; p_wx = 32'd1;
    p_gy = 32'hFFFF_FFFF; p_wy = 32'h8000_0000;
    p_gz = 32'd5;         p_wz = 32'hFFFF_FFFF;
    run_case("grid extremes R5");
  endtask

  // R2 R7: sparse enables pack densely; size rounded up
  task automatic t_sparse();
    load_defaults();
    p_props = 32'h0000_0052;
    run_case("sparse R2 R7");
    p_size = 32'd16;
    run_case("aligned size R7");
  endtask

  // R3 R4 R8 R9: all fields enabled, last two counts dropped
  task automatic t_all();
    load_defaults();
    p_props = 32'h0000_03FF;
    run_case("all fields R3 R8");
  endtask

  // R1: upper property bits are ignored
  task automatic t_upper_bits();
    load_defaults();
    p_props = 32'hFFFF_FC20;
    run_case("upper bits R1 R8");
  endtask

  // R6: zero work-group size, enabled and disabled dimension
  task automatic t_zero_wg();
    load_defaults();
    p_props = 32'h0000_0380;
    p_wy = 32'd0;
    run_case("zero wg enabled R6");
    p_props = 32'h0000_0180;
    p_wy = 32'd8;
    p_wz = 32'd0;
    run_case("zero wg disabled R6");
  endtask

  // R4: no enables gives done with no writes
  task automatic t_empty();
    load_defaults();
    p_props = 32'h0;
    run_case("empty R4");
  endtask

  // R11: restart while busy is ignored
  task automatic t_restart();
    int bw, bd;
    load_defaults();
    p_props = 32'h0000_0012;
    build_expected();
    bw = nw;
    bd = nd;
    pulse_start();
    repeat (4) @(negedge clk);
    p_props = 32'h0000_03FF;
    p_dp    = 64'h0;
    pulse_start();
    wait_done(bd);
    compare("restart R11", bw, bd);
    repeat (3) @(negedge clk);
    check(nd == bd + 1, "restart no second run R11", nd - bd, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired R10 actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_grid();
    t_sparse();
    t_all();
    t_upper_bits();
    t_zero_wg();
    t_empty();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule